// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Indicator

This block compares the divided reference signal of a frequency synthesizer with the divided oscillator signal, both already synchronous to the system clock. A rising edge on each side sets a flag of its own. Once both flags are set they are cleared together, so the overlap lasts one clock cycle. The flags drive two active-low correction outputs: "up" asks for a higher oscillator frequency and "down" asks for a lower one. A select input hands control to an external charge pump. In that mode both correction outputs are held low and a pump enable is raised.

A lock indicator watches the NAND of the two active-low pulses, which is high whenever a correction pulse is active. A digital filter replaces the external smoothing capacitor. Each rising edge of the reference marks the end of one comparison cycle. The filter declares lock after a set number of consecutive comparison cycles in which no pulse reached a set width. It drops lock in the cycle after a pulse reaches that width. The lock output models an open-drain pin: its enable is deasserted (pin released) while in lock, and asserted (pin pulled to 0) while out of lock.

Top module: `pfdLockDetect`

## Requirements
- R1: After reset, upN and dnN are 1, pulseNand is 0 and lockDriveEn is 1.
- R2: When refDiv rises d cycles before vcoDiv (d >= 1), upN is low for d+1 consecutive cycles and dnN is low for 1 cycle, starting in the cycle after the refDiv rise is sampled.
- R3: When vcoDiv rises d cycles before refDiv (d >= 1), dnN is low for d+1 cycles and upN is low for 1 cycle.
- R4: When both inputs rise in the same cycle, upN and dnN are low together for exactly one cycle (the reset window).
- R5: While cpSel is 1, upN and dnN are 0 and cpEn is 1. While cpSel is 0, cpEn is 0 and upN and dnN follow the detector.
- R6: lockDriveEn falls to 0 at the LOCK_CYCLES-th counted refDiv rising edge, with no wide pulse since reset or since the last loss of lock. A comparison cycle is counted at the refDiv rise that ends it.
- R7: A pulse that stays active for WIDE_LIMIT consecutive cycles sets lockDriveEn to 1 in the cycle after it reaches that width, and clears the count. The comparison cycle that contains the wide pulse is not counted.
- R8: The lock filter observes the internal detector pulses, so lock is gained and lost in the same way while cpSel is 1.
- R9: pulseNand is 1 in each cycle in which the up or down detector pulse is active (the NAND of the active-low pulses), in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refDiv | input | 1 | Divided reference, synchronous |
| vcoDiv | input | 1 | Divided oscillator, synchronous |
| cpSel | input | 1 | 1 = external charge pump mode, 0 = pulse outputs mode |
| upN | output | 1 | Up correction pulse, active low |
| dnN | output | 1 | Down correction pulse, active low |
| cpEn | output | 1 | Charge pump enable |
| pulseNand | output | 1 | NAND of the active-low detector pulses (raw lock signal) |
| lockDriveEn | output | 1 | 1 = lock pin pulled to 0 (out of lock), 0 = pin released (locked) |

## Verification
The bench builds the block with LOCK_CYCLES = 4 and WIDE_LIMIT = 4. With these values, lock is gained within four comparison windows. A lead of three cycles produces a four-cycle pulse, which is the shortest wide pulse, while a lead of two cycles stays narrow. Both sides of the width threshold, and the loss and re-acquisition of lock, therefore fit in a short run. Leads from -3 to +3 cycles are walked in both output modes.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  // Strobes passed from the detector control to the lock datapath
  typedef struct packed {
    logic cmpStart;     // reference rise: one comparison cycle ends
    logic pulseActive;  // an up or down pulse is active this cycle
  } pfdStrobe_t;
endpackage

// File: rtl/edgeCatch.sv
module edgeCatch #(
  parameter int NUM = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NUM-1:0] sigIn,
  output logic [NUM-1:0] riseOut
);
  logic [NUM-1:0] sigPrev;

  for (genvar i = 0; i < NUM; i++) begin : gChan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sigPrev[i] <= 1'b0;
      else       sigPrev[i] <= sigIn[i];
    end
    assign riseOut[i] = sigIn[i] & ~sigPrev[i];
  end
endmodule

// File: rtl/pfdCore.sv
module pfdCore
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       refRise,
  input  logic       vcoRise,
  output logic       upFlag,
  output logic       dnFlag,
  output pfdStrobe_t strobe
);
  logic clearBoth;
  logic upNext;
  logic dnNext;

  // Both flags set: clear them together. An edge in the clearing cycle re-arms its own flag.
  assign clearBoth = upFlag & dnFlag;

  always_comb begin
    if (clearBoth) begin
      upNext = refRise;
      dnNext = vcoRise;
    end else begin
      upNext = upFlag | refRise;
      dnNext = dnFlag | vcoRise;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upFlag <= 1'b0;
      dnFlag <= 1'b0;
    end else begin
      upFlag <= upNext;
      dnFlag <= dnNext;
    end
  end

  assign strobe.cmpStart    = refRise;
  assign strobe.pulseActive = upFlag | dnFlag;
endmodule

// File: rtl/lockFilter.sv
module lockFilter
  import pfd_pkg::*;
#(
  parameter int LOCK_CYCLES = 16,
  parameter int WIDE_LIMIT  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  pfdStrobe_t strobe,
  output logic       locked
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam int WW = $clog2(WIDE_LIMIT + 1);
  localparam logic [CW-1:0] LOCK_MAX  = CW'(LOCK_CYCLES);
  localparam logic [WW-1:0] WIDE_MAX  = WW'(WIDE_LIMIT);
  localparam logic [WW-1:0] WIDE_EDGE = WW'(WIDE_LIMIT - 1);

  logic [WW-1:0] widthCnt;
  logic [CW-1:0] lockCount;
  logic          cycleDirty;
  logic          wideNow;

  // Length of the current run of active pulse cycles, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   widthCnt <= '0;
    else if (!strobe.pulseActive) widthCnt <= '0;
    else if (widthCnt != WIDE_MAX) widthCnt <= widthCnt + 1'b1;
  end

  assign wideNow = strobe.pulseActive && (widthCnt >= WIDE_EDGE);

  // Marks a comparison cycle that contained a wide pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cycleDirty <= 1'b0;
    else if (strobe.cmpStart) cycleDirty <= wideNow;
    else if (wideNow)         cycleDirty <= 1'b1;
  end

  // Counts consecutive clean comparison cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      lockCount <= '0;
    else if (wideNow)
      lockCount <= '0;
    else if (strobe.cmpStart && !cycleDirty && lockCount != LOCK_MAX)
      lockCount <= lockCount + 1'b1;
  end

  assign locked = (lockCount == LOCK_MAX);
endmodule

// File: rtl/pfdLockDetect.sv
module pfdLockDetect
  import pfd_pkg::*;
#(
  parameter int LOCK_CYCLES = 16,
  parameter int WIDE_LIMIT  = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic refDiv,
  input  logic vcoDiv,
  input  logic cpSel,
  output logic upN,
  output logic dnN,
  output logic cpEn,
  output logic pulseNand,
  output logic lockDriveEn
);
  logic [1:0] rises;
  logic       refRise;
  logic       vcoRise;
  logic       upFlag;
  logic       dnFlag;
  logic       locked;
  pfdStrobe_t strobe;

  edgeCatch #(.NUM(2)) uEdge (
    .clk(clk), .rstN(rstN), .sigIn({vcoDiv, refDiv}), .riseOut(rises)
  );
  assign refRise = rises[0];
  assign vcoRise = rises[1];

  pfdCore uCore (
    .clk(clk), .rstN(rstN), .refRise(refRise), .vcoRise(vcoRise),
    .upFlag(upFlag), .dnFlag(dnFlag), .strobe(strobe)
  );

  lockFilter #(.LOCK_CYCLES(LOCK_CYCLES), .WIDE_LIMIT(WIDE_LIMIT)) uFilt (
    .clk(clk), .rstN(rstN), .strobe(strobe), .locked(locked)
  );

  assign upN         = cpSel ? 1'b0 : ~upFlag;
  assign dnN         = cpSel ? 1'b0 : ~dnFlag;
  assign cpEn        = cpSel;
  assign pulseNand   = ~((~upFlag) & (~dnFlag));
  assign lockDriveEn = ~locked;
endmodule

// File: rtl/pfdLockDetect_chk.sv
module pfdLockDetect_chk (
  input logic clk,
  input logic rstN,
  input logic cpSel,
  input logic upN,
  input logic dnN,
  input logic cpEn,
  input logic pulseNand,
  input logic lockDriveEn,
  input logic refRise,
  input logic vcoRise
);
  AST_CP_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    cpSel |-> (!upN && !dnN && cpEn)); // R5

  AST_OVERLAP_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    (!cpSel && !upN && !dnN && !(refRise && vcoRise)) |=> (upN || dnN || cpSel)); // R4

  AST_LOCK_ON_REF: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockDriveEn) |-> $past(refRise)); // R6

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!lockDriveEn && !pulseNand) |=> !lockDriveEn); // R6

  AST_DROP_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockDriveEn) |-> $past(pulseNand)); // R7
endmodule

bind pfdLockDetect pfdLockDetect_chk uChk (
  .clk(clk), .rstN(rstN), .cpSel(cpSel), .upN(upN), .dnN(dnN), .cpEn(cpEn),
  .pulseNand(pulseNand), .lockDriveEn(lockDriveEn),
  .refRise(refRise), .vcoRise(vcoRise)
);

// File: tb/tb_pfdLockDetect.sv
`timescale 1ns/1ps
module tb_pfdLockDetect;
  localparam int LOCKN = 4;
  localparam int WIDEN = 4;
  localparam int WIN   = 24;
  // {vco delay vs ref, expected up-low cycles, expected dn-low cycles, expected nand-high cycles}
  localparam int VEC [0:6][0:3] = '{
    '{-3, 1, 4, 4}, '{-2, 1, 3, 3}, '{-1, 1, 2, 2}, '{0, 1, 1, 1},
    '{ 1, 2, 1, 2}, '{ 2, 3, 1, 3}, '{ 3, 4, 1, 4}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refDiv = 1'b0;
  logic vcoDiv = 1'b0;
  logic cpSel = 1'b0;
  logic upN, dnN, cpEn, pulseNand, lockDriveEn;
  int   nTests = 0;
  int   nFail  = 0;
  bit   done   = 1'b0;
  int   upLow, dnLow, nandHigh, cpOnes;

  always #2.5 clk = ~clk;

  pfdLockDetect #(.LOCK_CYCLES(LOCKN), .WIDE_LIMIT(WIDEN)) dut (
    .clk(clk), .rstN(rstN), .refDiv(refDiv), .vcoDiv(vcoDiv), .cpSel(cpSel),
    .upN(upN), .dnN(dnN), .cpEn(cpEn), .pulseNand(pulseNand), .lockDriveEn(lockDriveEn)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One comparison window: ref rises at t=5, vco at t=5+d, both held 8 cycles
  task automatic runWindow(input int d);
    upLow = 0; dnLow = 0; nandHigh = 0; cpOnes = 0;
    for (int t = 0; t < WIN; t++) begin
      @(negedge clk);
      if (!upN) upLow++;
      if (!dnN) dnLow++;
      if (pulseNand) nandHigh++;
      if (cpEn) cpOnes++;
      refDiv = (t >= 5) && (t < 13);
      vcoDiv = (t >= 5 + d) && (t < 13 + d);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    refDiv = 1'b0;
    vcoDiv = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    doReset();
    check("R1", "upN after reset", upN, 1);
    check("R1", "dnN after reset", dnN, 1);
    check("R1", "pulseNand after reset", pulseNand, 0);
    check("R1", "lockDriveEn after reset", lockDriveEn, 1);

    // Lead table in pulse-output mode: d>0 R2, d<0 R3, d=0 R4, nand width R9
    for (int i = 0; i < 7; i++) begin
      runWindow(VEC[i][0]);
      check(VEC[i][0] > 0 ? "R2" : (VEC[i][0] < 0 ? "R3" : "R4"), "up low cycles", upLow, VEC[i][1]);
      check(VEC[i][0] > 0 ? "R2" : (VEC[i][0] < 0 ? "R3" : "R4"), "dn low cycles", dnLow, VEC[i][2]);
      check("R9", "nand high cycles", nandHigh, VEC[i][3]);
      check("R5", "cpEn low in pulse mode", cpOnes, 0);
    end

    // Lock acquisition R6
    doReset();
    for (int w = 1; w <= LOCKN; w++) begin
      runWindow(0);
      check("R6", $sformatf("lockDriveEn after window %0d", w), lockDriveEn, (w < LOCKN) ? 1 : 0);
    end
    runWindow(2);
    check("R6", "lock kept on narrow pulse", lockDriveEn, 0);

    // Wide pulse drops lock, its cycle is not counted R7
    runWindow(3);
    check("R7", "lock dropped by wide pulse", lockDriveEn, 1);
    for (int w = 1; w <= LOCKN + 1; w++) begin
      runWindow(0);
      check("R7", $sformatf("relock window %0d", w), lockDriveEn, (w <= LOCKN) ? 1 : 0);
    end
    runWindow(-3);
    check("R7", "lock dropped by wide down pulse", lockDriveEn, 1);

    // Charge pump mode R5, R8, R9
    cpSel = 1'b1;
    runWindow(2);
    check("R5", "upN held low in pump mode", upLow, WIN);
    check("R5", "dnN held low in pump mode", dnLow, WIN);
    check("R5", "cpEn high in pump mode", cpOnes, WIN);
    check("R9", "nand width in pump mode", nandHigh, 3);
    for (int w = 1; w <= LOCKN + 1; w++) runWindow(0);
    check("R8", "locked in pump mode", lockDriveEn, 0);
    runWindow(3);
    check("R8", "lock dropped in pump mode", lockDriveEn, 1);

    cpSel = 1'b0;
    runWindow(1);
    check("R5", "cpEn back low", cpOnes, 0);
    check("R2", "up low cycles after pump mode", upLow, 2);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule